// File: doc/BRIEF.md
# Packet Descriptor Queue Host Interface

This block sits between a host register bus and a packet-moving engine. Software describes a buffer with three 32-bit words: a size word whose top nibble carries flags, the high half of a 64-bit buffer address and the low half of that address. The first two words are held in staging registers. Writing the low address word assembles the full 96-bit descriptor and pushes it into an input queue, which the engine drains through a valid/ready stream port.

The engine hands finished descriptors back through a second stream port into an output queue. Software reads them at the same three offsets. The size and high words show the oldest completion without removing it. Reading the low word returns that word and removes the entry.

A control/status word holds an interrupt enable and a completion-pending flag. The interrupt line is the logical AND of the two. The same word reports read-only queue and fault status, and it has a self-clearing soft reset. The register window spans 32 bytes and is byte addressed: tag at 0x00, control at 0x04, size/flags at 0x08, address-high at 0x0C, address-low at 0x10. Offsets 0x14 to 0x1C are unused.

Top module: `pkt_desc_fifo_if`

## Requirements
- R1: After reset the control word reads 0x0000_0020 (only the output-empty flag, bit 5), irq is low, dev_desc_valid is low and offset 0x00 reads the TAG parameter.
- R2: Writes to size/flags (0x08) or address-high (0x0C) alone push nothing. A write to address-low (0x10) pushes {size/flags with bit 31 cleared, high, low} as data bits [95:64], [63:32], [31:0].
- R3: Descriptors leave the input queue in the order written. Control bit 4 reads 1 while DEPTH descriptors are waiting.
- R4: A write to address-low while the input queue is full discards the descriptor and sets control bit 31 (error). The error stays set until a soft reset.
- R5: Each accepted completion is stored with bit 95 (the done flag, bit 31 of size/flags) forced to 1. Reads of 0x08 and 0x0C return the oldest entry's words without removing it. A read of 0x10 returns its low word and removes it, and completions come out in arrival order.
- R6: A read of 0x10 while the output queue is empty returns zero and removes nothing.
- R7: Control bit 2 (done) is set when a completion is accepted and cleared by writing 1 to it. Control bit 1 is the interrupt enable, and irq equals done AND enable.
- R8: Writing 1 to control bit 0 empties both queues and clears done, error, underrun and the staged size/high words. The interrupt enable takes the value written with it, and bit 0 always reads 0.
- R9: A pulse on dev_starve sets control bit 6 (receiver out of buffers). The bit stays set until a soft reset.
- R10: cmp_ready is low while the output queue holds DEPTH entries.
- R11: Writes to control bits 31 and 6:3 do not change them. Only bits 0, 1 and 2 take software writes.
- R12: Offsets 0x14 to 0x1C read as zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on offset 0x10) |
| reg_addr | input | 5 | Byte offset within the 32-byte window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from current state |
| dev_desc_valid | output | 1 | Input queue has a descriptor for the engine |
| dev_desc_ready | input | 1 | Engine takes the descriptor |
| dev_desc_data | output | 96 | Descriptor {size/flags, addr high, addr low} |
| cmp_valid | input | 1 | Engine offers a completion |
| cmp_ready | output | 1 | Output queue can accept |
| cmp_data | input | 96 | Completion descriptor |
| dev_starve | input | 1 | Engine reports receive buffers exhausted |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest state to reach from the ports is the overflow drop. The input queue has to be full, which needs the engine to stall while software keeps committing, and then one more low-word write has to arrive. The bench holds dev_desc_ready low, commits DEPTH+1 descriptors and then releases the engine. The scoreboard must then see exactly DEPTH items in order with the extra one missing. The soft reset is checked by staging size and high words just before it and then committing only a low word, so that any leftover staged value shows up in the pushed descriptor.

// File: rtl/pdf_pkg.sv
package pdf_pkg;
   localparam int REG_AW = 5;
   localparam int WORD_W = 32;
   localparam int DESC_W = 3 * WORD_W;

   localparam logic [REG_AW-1:0] OFS_TAG  = 5'h00;
   localparam logic [REG_AW-1:0] OFS_CTRL = 5'h04;
   localparam logic [REG_AW-1:0] OFS_SF   = 5'h08;
   localparam logic [REG_AW-1:0] OFS_HI   = 5'h0C;
   localparam logic [REG_AW-1:0] OFS_LO   = 5'h10;

   localparam int CB_RST      = 0;
   localparam int CB_IE       = 1;
   localparam int CB_DONE     = 2;
   localparam int CB_INFULL   = 4;
   localparam int CB_OUTEMPTY = 5;
   localparam int CB_STARVE   = 6;
   localparam int CB_ERR      = 31;
   localparam int SF_DONE     = 31;

   typedef struct packed {
      logic [WORD_W-1:0] sf;
      logic [WORD_W-1:0] hi;
      logic [WORD_W-1:0] lo;
   } desc_t;
endpackage

// File: rtl/pdf_fifo.sv
module pdf_fifo #(
   parameter int WIDTH = 96,
   parameter int DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] rdata,
   output logic             full,
   output logic             empty
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("pdf_fifo: DEPTH must be a power of two, at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("pdf_fifo: WIDTH must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW:0]      wp, rp;

   assign empty = (wp == rp);
   assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
   assign rdata = mem[rp[AW-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
      end else if (flush) begin
         wp <= '0;
         rp <= '0;
      end else begin
         if (push) wp <= wp + 1'b1;
         if (pop)  rp <= rp + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push && !flush) mem[wp[AW-1:0]] <= wdata;
   end

   // R3
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full)
      else $error("push into full queue");

   // R6
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty)
      else $error("pop from empty queue");
endmodule

// File: rtl/pdf_ctrl.sv
module pdf_ctrl
   import pdf_pkg::*;
#(
   parameter logic [WORD_W-1:0] TAG = 32'h0000_0001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [WORD_W-1:0] reg_wdata,
   output logic [WORD_W-1:0] reg_rdata,
   input  logic              in_full,
   output logic              in_push,
   output desc_t             in_desc,
   input  logic              out_empty,
   input  desc_t             out_head,
   output logic              out_pop,
   input  logic              cmp_push,
   input  logic              dev_starve,
   output logic              flush,
   output logic              irq
);
   logic              ie_q, done_q, err_q, starve_q;
   logic [WORD_W-1:0] sf_q, hi_q;
   logic              wr_ctrl, wr_sf, wr_hi, wr_lo, rd_lo;

   assign wr_ctrl = reg_wr && (reg_addr == OFS_CTRL);
   assign wr_sf   = reg_wr && (reg_addr == OFS_SF);
   assign wr_hi   = reg_wr && (reg_addr == OFS_HI);
   assign wr_lo   = reg_wr && (reg_addr == OFS_LO);
   assign rd_lo   = reg_rd && (reg_addr == OFS_LO);

   assign flush   = wr_ctrl && reg_wdata[CB_RST];
   assign in_push = wr_lo && !in_full;
   assign out_pop = rd_lo && !out_empty;

   always_comb begin
      in_desc     = '{sf: sf_q, hi: hi_q, lo: reg_wdata};
      in_desc.sf[SF_DONE] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie_q     <= 1'b0;
         done_q   <= 1'b0;
         err_q    <= 1'b0;
         starve_q <= 1'b0;
         sf_q     <= '0;
         hi_q     <= '0;
      end else begin
         if (wr_ctrl) ie_q <= reg_wdata[CB_IE];
         if (flush) begin
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            starve_q <= 1'b0;
            sf_q     <= '0;
            hi_q     <= '0;
         end else begin
            if (cmp_push)                           done_q <= 1'b1;
            else if (wr_ctrl && reg_wdata[CB_DONE]) done_q <= 1'b0;
            if (wr_lo && in_full) err_q    <= 1'b1;
            if (dev_starve)       starve_q <= 1'b1;
            if (wr_sf)            sf_q     <= reg_wdata;
            if (wr_hi)            hi_q     <= reg_wdata;
         end
      end
   end

   assign irq = done_q && ie_q;

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         OFS_TAG:  reg_rdata = TAG;
         OFS_CTRL: begin
            reg_rdata[CB_IE]       = ie_q;
            reg_rdata[CB_DONE]     = done_q;
            reg_rdata[CB_INFULL]   = in_full;
            reg_rdata[CB_OUTEMPTY] = out_empty;
            reg_rdata[CB_STARVE]   = starve_q;
            reg_rdata[CB_ERR]      = err_q;
         end
         OFS_SF:   reg_rdata = out_empty ? '0 : out_head.sf;
         OFS_HI:   reg_rdata = out_empty ? '0 : out_head.hi;
         OFS_LO:   reg_rdata = out_empty ? '0 : out_head.lo;
         default:  reg_rdata = '0;
      endcase
   end

   // R7
   done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_push && !flush) |=> done_q)
      else $error("accepted completion did not raise done");

   // R4
   err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo && in_full) |=> err_q)
      else $error("dropped descriptor did not raise error");

   // R8
   flush_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (!done_q && !err_q && !starve_q && !irq))
      else $error("soft reset left status set");
endmodule

// File: rtl/pkt_desc_fifo_if.sv
module pkt_desc_fifo_if
   import pdf_pkg::*;
#(
   parameter int                DEPTH = 8,
   parameter logic [WORD_W-1:0] TAG   = 32'h0000_0001
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [WORD_W-1:0] reg_wdata,
   output logic [WORD_W-1:0] reg_rdata,
   output logic              dev_desc_valid,
   input  logic              dev_desc_ready,
   output logic [DESC_W-1:0] dev_desc_data,
   input  logic              cmp_valid,
   output logic              cmp_ready,
   input  logic [DESC_W-1:0] cmp_data,
   input  logic              dev_starve,
   output logic              irq
);
   localparam logic [DESC_W-1:0] CMP_DONE_MASK = {1'b1, {(DESC_W-1){1'b0}}};

   logic  flush, in_push, in_full, in_empty, in_pop;
   logic  out_push, out_pop, out_full, out_empty;
   desc_t in_desc, in_head, out_head;

   assign dev_desc_valid = !in_empty;
   assign in_pop         = dev_desc_valid && dev_desc_ready;
   assign dev_desc_data  = in_head;
   assign cmp_ready      = !out_full;
   assign out_push       = cmp_valid && cmp_ready;

   pdf_fifo #(.WIDTH(DESC_W), .DEPTH(DEPTH)) u_in_q (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .push(in_push), .wdata(in_desc),
      .pop(in_pop), .rdata(in_head),
      .full(in_full), .empty(in_empty)
   );

   pdf_fifo #(.WIDTH(DESC_W), .DEPTH(DEPTH)) u_out_q (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .push(out_push), .wdata(cmp_data | CMP_DONE_MASK),
      .pop(out_pop), .rdata(out_head),
      .full(out_full), .empty(out_empty)
   );

   pdf_ctrl #(.TAG(TAG)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .in_full(in_full), .in_push(in_push), .in_desc(in_desc),
      .out_empty(out_empty), .out_head(out_head), .out_pop(out_pop),
      .cmp_push(out_push), .dev_starve(dev_starve),
      .flush(flush), .irq(irq)
   );

   // R5
   cmp_done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_empty |-> out_head.sf[SF_DONE])
      else $error("stored completion lacks done flag");
endmodule

// File: tb/pkt_desc_fifo_if_bench.sv
module pkt_desc_fifo_if_bench;
   localparam int DEPTH = 8;
   localparam logic [31:0] TAGV = 32'h0000_0001;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        dev_desc_valid, dev_desc_ready = 1'b0;
   logic [95:0] dev_desc_data;
   logic        cmp_valid = 1'b0, cmp_ready;
   logic [95:0] cmp_data = '0;
   logic        dev_starve = 1'b0;
   logic        irq;

   int tests = 0, fails = 0;
   logic [95:0] exp_q[$];
   logic [95:0] cmp_q[$];
   logic        finished = 1'b0;

   always #2 clk = ~clk;

   pkt_desc_fifo_if #(.DEPTH(DEPTH), .TAG(TAGV)) u_pkt_desc_fifo_if (.*);

   task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: descriptors reaching the engine, in order (R2, R3)
   always @(negedge clk) begin
      if (rst_n && dev_desc_valid && dev_desc_ready) begin
         if (exp_q.size() == 0) chk("R3 unexpected descriptor", dev_desc_data, '0);
         else chk("R2/R3 descriptor", dev_desc_data, exp_q.pop_front());
      end
   end

   task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk); d = reg_rdata;
      @(posedge clk); #1;
      reg_rd = 1'b0;
   endtask

   task automatic submit(input logic [31:0] sf, input logic [31:0] hi, input logic [31:0] lo,
                         input bit expect_taken);
      bus_wr(5'h08, sf);
      bus_wr(5'h0C, hi);
      bus_wr(5'h10, lo);
      if (expect_taken) exp_q.push_back({1'b0, sf[30:0], hi, lo});
   endtask

   task automatic complete(input logic [95:0] d);
      cmp_valid = 1'b1; cmp_data = d;
      @(posedge clk); #1;
      cmp_valid = 1'b0;
      cmp_q.push_back({1'b1, d[94:0]});
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
   endtask

   initial begin
      logic [31:0] r;
      logic [95:0] e;
      idle(2);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      bus_rd(5'h04, r); chk("R1 ctrl", r, 32'h0000_0020);
      bus_rd(5'h00, r); chk("R1 tag", r, TAGV);
      chk("R1 irq", irq, 0);
      chk("R1 valid", dev_desc_valid, 0);

      // R2 staging words alone push nothing
      bus_wr(5'h08, 32'h9000_0040);
      bus_wr(5'h0C, 32'h0000_0001);
      @(negedge clk); chk("R2 no push on staging", dev_desc_valid, 0); @(posedge clk); #1;
      bus_wr(5'h10, 32'h1000_2000);
      exp_q.push_back({32'h1000_0040, 32'h0000_0001, 32'h1000_2000});
      @(negedge clk); chk("R2 push on low word", dev_desc_valid, 1); @(posedge clk); #1;

      // R3 fill; R4 overflow drop
      for (int i = 1; i < DEPTH; i++)
         submit(32'h2000_0000 + i, 32'hA000_0000 + i, 32'hB000_0000 + i, 1'b1);
      bus_rd(5'h04, r); chk("R3 in-full flag", r, 32'h0000_0030);
      submit(32'h0000_0FFF, 32'hDEAD_0000, 32'hDEAD_BEEF, 1'b0);
      bus_rd(5'h04, r); chk("R4 error set on drop", r, 32'h8000_0030);
      dev_desc_ready = 1'b1;
      idle(DEPTH + 4);
      chk("R3 all delivered", exp_q.size(), 0);
      bus_rd(5'h04, r); chk("R4 error sticky", r, 32'h8000_0020);

      // R11 status bits read-only
      bus_wr(5'h04, 32'hFFFF_FFF0);
      bus_rd(5'h04, r); chk("R11 status unchanged", r, 32'h8000_0020);

      // R5 completions, R7 done/irq
      complete({32'h1000_0100, 32'h0000_0002, 32'h0000_1000});
      complete({32'h2000_0008, 32'h0000_0003, 32'h0000_2000});
      complete({32'h0000_0010, 32'h0000_0004, 32'h0000_3000});
      bus_rd(5'h04, r); chk("R7 done set", r, 32'h8000_0004);
      chk("R7 irq masked", irq, 0);
      e = cmp_q.pop_front();
      bus_rd(5'h08, r); chk("R5 peek sf", r, e[95:64]);
      bus_rd(5'h0C, r); chk("R5 peek hi", r, e[63:32]);
      bus_rd(5'h08, r); chk("R5 peek no pop", r, e[95:64]);
      bus_rd(5'h10, r); chk("R5 pop lo", r, e[31:0]);
      bus_wr(5'h04, 32'h0000_0002);
      @(negedge clk); chk("R7 irq on enable", irq, 1); @(posedge clk); #1;
      bus_wr(5'h04, 32'h0000_0006);
      @(negedge clk); chk("R7 irq after w1c", irq, 0); @(posedge clk); #1;
      bus_rd(5'h04, r); chk("R7 done cleared", r, 32'h8000_0002);
      while (cmp_q.size() > 0) begin
         e = cmp_q.pop_front();
         bus_rd(5'h08, r); chk("R5 order sf", r, e[95:64]);
         bus_rd(5'h10, r); chk("R5 order lo", r, e[31:0]);
      end

      // R6 empty read
      bus_rd(5'h10, r); chk("R6 empty read zero", r, 0);
      complete({32'h0, 32'h0, 32'h0000_00AA});
      e = cmp_q.pop_front();
      bus_rd(5'h10, r); chk("R6 next entry intact", r, e[31:0]);

      // R10 backpressure
      for (int i = 0; i < DEPTH; i++) complete({32'h0, 32'h0, 32'h0000_0100 + i});
      @(negedge clk); chk("R10 cmp_ready low when full", cmp_ready, 0); @(posedge clk); #1;

      // R9 starvation flag
      dev_starve = 1'b1; idle(1); dev_starve = 1'b0;
      bus_rd(5'h04, r); chk("R9 starve flag", r, 32'h8000_0046);
      chk("R7 irq with enable", irq, 1);

      // R8 soft reset
      dev_desc_ready = 1'b0;
      bus_wr(5'h08, 32'h1234_5678);
      bus_wr(5'h0C, 32'h8765_4321);
      bus_wr(5'h04, 32'h0000_0003);
      cmp_q.delete();
      bus_rd(5'h04, r); chk("R8 ctrl after soft reset", r, 32'h0000_0022);
      chk("R8 irq low", irq, 0);
      chk("R8 cmp_ready back", cmp_ready, 1);
      bus_rd(5'h10, r); chk("R8 output queue flushed", r, 0);
      bus_wr(5'h10, 32'h0000_0055);
      exp_q.push_back({32'h0, 32'h0, 32'h0000_0055});
      dev_desc_ready = 1'b1;
      idle(3);
      chk("R8 staged words cleared", exp_q.size(), 0);

      // R12 unused offsets
      dev_desc_ready = 1'b0;
      bus_rd(5'h14, r); chk("R12 read 0x14", r, 0);
      bus_wr(5'h18, 32'hFFFF_FFFF);
      bus_wr(5'h1C, 32'hFFFF_FFFF);
      bus_rd(5'h04, r); chk("R12 ctrl unchanged", r, 32'h0000_0022);
      chk("R12 no push", dev_desc_valid, 0);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(4 * 100000);
      if (!finished) begin
         tests++; fails++;
         $display("FAIL watchdog expired actual=hung expected=complete");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule